// File: doc/BRIEF.md
# Serial Flash Command Front-End

This block is the slave side of a four-wire serial link into a 4 MB NOR flash. It works in the system clock domain. Each serial pin passes through a synchronizer, and the block finds the clock and select edges by comparing successive samples. It takes input bits on serial clock rising edges and changes the output bit on falling edges (mode 0, most significant bit first). It collects an opcode, a 24-bit address and, where the command needs one, a dummy byte. It then starts the data phase of that command.

Read commands fetch bytes through a synchronous memory port with one cycle of latency and shift them out. The identification, status and signature commands shift out fixed or supplied bytes. Write-type commands go to an external status and protection controller as a one-cycle commit pulse that carries a kind code and an address. Program and status-write data bytes are streamed to that controller first. The block holds a single deep power-down flag of its own.

Serial clock high and low times must each be at least six system clock periods. Select must stay high for at least four.

Top module: `spi_flash_frontend`

## Requirements
- R1: After reset and whenever select is high or no data phase is running, `miso_oe_o` is 0. After reset, `powered_down_o`, `mem_rd_o`, `cmd_commit_o` and `wr_data_vld_o` are 0.
- R2: Read (03h) followed by three address bytes returns the memory byte at that address. The first bit appears after the falling edge that follows the last address bit. Address bits 23 and 22 are ignored.
- R3: During a read the address goes up by one for each byte returned, and it wraps from 3FFFFFh to 000000h.
- R4: Fast read (0Bh) expects one dummy byte after the address before data starts.
- R5: Read identification (9Fh) returns 20h, 20h, 16h and then repeats that three-byte cycle.
- R6: Read status (05h) returns `status_i` as it stands at the start of each returned byte.
- R7: A write-type command commits only when select rises on a byte boundary after all of its required bytes. The required bytes are: the opcode alone for 06h, 04h, C7h and B9h; the opcode and three address bytes for D8h; the opcode, address and at least one data byte for 02h; the opcode and one data byte for 01h. The commit pulse carries `cmd_kind_o` (0 for 06h, 1 for 04h, 2 for 01h, 3 for 02h, 4 for D8h, 5 for C7h) and the 22-bit address in `cmd_addr_o`.
- R8: Each data byte of a page program or status write is pulsed out on `wr_data_o` with `wr_data_vld_o`.
- R9: While `busy_i` is high, every opcode except read status is ignored: no output, no memory read and no commit.
- R10: A valid B9h sets `powered_down_o`. If `busy_i` is high, the request is rejected.
- R11: While powered down, every opcode except ABh is ignored.
- R12: ABh clears power-down as soon as its opcode byte arrives, even if select rises right after it. After three dummy bytes it returns 15h repeatedly.
- R13: An unknown opcode is ignored until select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock |
| csn_i | input | 1 | Chip select, active low |
| mosi_i | input | 1 | Serial data in |
| miso_o | output | 1 | Serial data out |
| miso_oe_o | output | 1 | Output enable for miso_o |
| busy_i | input | 1 | Write, program or erase cycle running |
| status_i | input | 8 | Status byte for read status |
| mem_rd_o | output | 1 | Array read strobe |
| mem_addr_o | output | 22 | Array read address |
| mem_rdata_i | input | 8 | Array data, valid one cycle after the strobe |
| cmd_commit_o | output | 1 | Write-type command commit pulse |
| cmd_kind_o | output | 3 | Kind of committed command |
| cmd_addr_o | output | 22 | Address of committed command |
| wr_data_o | output | 8 | Program or status-write data byte |
| wr_data_vld_o | output | 1 | Data byte valid pulse |
| powered_down_o | output | 1 | Deep power-down active |

## Verification
A select rise at the pin produces a commit pulse on the third system clock edge after it: two synchronizer stages, then the commit register. The bench waits twelve clocks after every select rise before it reads its commit and data counters. A returned bit appears about four clocks after the serial clock falls. The bench holds each serial clock level for eight system clocks and samples `miso_o` at the end of the low half, just before the rising edge, so each bit is read when it is stable. The one-cycle memory fetch is issued at least six clocks before the falling edge that needs its data.

// File: rtl/sfl_pkg.sv
package sfl_pkg;
  typedef enum logic [2:0] {
    PH_OP, PH_ADDR, PH_DUMMY, PH_DOUT, PH_DIN, PH_HOLD, PH_SKIP
  } phase_e;

  typedef enum logic [2:0] {
    WK_WREN = 3'd0, WK_WRDI = 3'd1, WK_WRSR = 3'd2,
    WK_PP   = 3'd3, WK_SE   = 3'd4, WK_BE   = 3'd5
  } wkind_e;

  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDID = 8'h9F;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_FAST = 8'h0B;
  localparam logic [7:0] OP_PP   = 8'h02;
  localparam logic [7:0] OP_SE   = 8'hD8;
  localparam logic [7:0] OP_BE   = 8'hC7;
  localparam logic [7:0] OP_DP   = 8'hB9;
  localparam logic [7:0] OP_RES  = 8'hAB;

  localparam logic [7:0] ID_MFR  = 8'h20;
  localparam logic [7:0] ID_TYPE = 8'h20;
  localparam logic [7:0] ID_CAP  = 8'h16;
  localparam logic [7:0] SIG_BYTE = 8'h15;

  localparam int ADDR_BYTES = 3;
endpackage

// File: rtl/sfl_sync.sv
module sfl_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] st_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q[g] <= RST_VAL;
      else if (g == 0) st_q[g] <= d_i;
      else st_q[g] <= st_q[(g == 0) ? 0 : g-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/sfl_rx.sv
module sfl_rx #(
  parameter int BYTE_W = 8,
  localparam int BIT_W = $clog2(BYTE_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_active_i,
  input  logic              sck_rise_i,
  input  logic              sdi_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_vld_o,
  output logic [BIT_W-1:0]  bit_cnt_o
);
  logic [BYTE_W-1:0] sh_q;
  logic [BIT_W-1:0]  bit_cnt_q;
  logic              byte_vld_q;
  logic              last_bit;

  assign last_bit = (bit_cnt_q == BIT_W'(BYTE_W-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q       <= '0;
      bit_cnt_q  <= '0;
      byte_vld_q <= 1'b0;
    end else begin
      byte_vld_q <= 1'b0;
      if (!cs_active_i) begin
        bit_cnt_q <= '0;
      end else if (sck_rise_i) begin
        sh_q       <= {sh_q[BYTE_W-2:0], sdi_i};
        bit_cnt_q  <= last_bit ? '0 : bit_cnt_q + 1'b1;
        byte_vld_q <= last_bit;
      end
    end
  end

  assign byte_o     = sh_q;
  assign byte_vld_o = byte_vld_q;
  assign bit_cnt_o  = bit_cnt_q;

  assert_cnt_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_active_i |=> bit_cnt_q == '0);
  assert_byte_on_edge_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_q |-> $past(sck_rise_i));
endmodule

// File: rtl/sfl_tx.sv
module sfl_tx #(
  parameter int BYTE_W = 8,
  localparam int BIT_W = $clog2(BYTE_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_active_i,
  input  logic              dout_i,
  input  logic              sck_fall_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              load_o,
  output logic              sdo_o,
  output logic              oe_o
);
  logic [BYTE_W-1:0] sh_q;
  logic [BIT_W-1:0]  bit_q;
  logic              sdo_q, oe_q, shift_en;

  assign shift_en = cs_active_i && dout_i && sck_fall_i;
  assign load_o   = shift_en && (bit_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      bit_q <= '0;
      sdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else if (!(cs_active_i && dout_i)) begin
      bit_q <= '0;
      sdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else if (shift_en) begin
      oe_q  <= 1'b1;
      bit_q <= (bit_q == BIT_W'(BYTE_W-1)) ? '0 : bit_q + 1'b1;
      if (bit_q == '0) begin
        sdo_q <= byte_i[BYTE_W-1];
        sh_q  <= {byte_i[BYTE_W-2:0], 1'b0};
      end else begin
        sdo_q <= sh_q[BYTE_W-1];
        sh_q  <= {sh_q[BYTE_W-2:0], 1'b0};
      end
    end
  end

  assign sdo_o = sdo_q;
  assign oe_o  = oe_q;

  assert_oe_needs_phase_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_q |-> $past(cs_active_i && dout_i));
  assert_load_drives_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> oe_q);
endmodule

// File: rtl/sfl_ctrl.sv
module sfl_ctrl
  import sfl_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int BYTE_W = 8,
  localparam int BIT_W = $clog2(BYTE_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_active_i,
  input  logic              cs_rise_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              byte_vld_i,
  input  logic [BIT_W-1:0]  bit_cnt_i,
  input  logic              load_i,
  input  logic              busy_i,
  input  logic [BYTE_W-1:0] status_i,
  input  logic [BYTE_W-1:0] mem_rdata_i,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [BYTE_W-1:0] tx_byte_o,
  output logic              dout_o,
  output logic              commit_o,
  output logic [2:0]        kind_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              wr_data_vld_o,
  output logic              pd_o
);
  phase_e            phase_q;
  logic [7:0]        op_q;
  logic [ADDR_W-1:0] addr_q, mem_addr_q, addr_nxt;
  logic [ADDR_W+BYTE_W-1:0] addr_cat;
  logic [1:0]        cnt_q, id_idx_q;
  logic              armed_q, pd_q, mem_rd_q, rd_pend_q, commit_q, wvld_q;
  logic [BYTE_W-1:0] rd_buf_q, wdata_q;
  wkind_e            kind_q;
  logic              is_read;

  assign addr_cat = {addr_q, byte_i};
  assign addr_nxt = addr_cat[ADDR_W-1:0];
  assign is_read  = (op_q == OP_READ) || (op_q == OP_FAST);

  function automatic wkind_e kind_of(input logic [7:0] op);
    case (op)
      OP_WREN: return WK_WREN;
      OP_WRDI: return WK_WRDI;
      OP_WRSR: return WK_WRSR;
      OP_PP:   return WK_PP;
      OP_SE:   return WK_SE;
      default: return WK_BE;
    endcase
  endfunction

  always_comb begin
    case (op_q)
      OP_RDSR: tx_byte_o = status_i;
      OP_RES:  tx_byte_o = SIG_BYTE;
      OP_RDID: tx_byte_o = (id_idx_q == 2'd0) ? ID_MFR :
                           (id_idx_q == 2'd1) ? ID_TYPE : ID_CAP;
      default: tx_byte_o = rd_buf_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q    <= PH_OP;
      op_q       <= '0;
      addr_q     <= '0;
      mem_addr_q <= '0;
      cnt_q      <= '0;
      id_idx_q   <= '0;
      armed_q    <= 1'b0;
      pd_q       <= 1'b0;
      mem_rd_q   <= 1'b0;
      rd_pend_q  <= 1'b0;
      rd_buf_q   <= '0;
      commit_q   <= 1'b0;
      kind_q     <= WK_WREN;
      wvld_q     <= 1'b0;
      wdata_q    <= '0;
    end else begin
      mem_rd_q  <= 1'b0;
      commit_q  <= 1'b0;
      wvld_q    <= 1'b0;
      rd_pend_q <= mem_rd_q;
      if (rd_pend_q) rd_buf_q <= mem_rdata_i;

      if (cs_rise_i) begin
        phase_q <= PH_OP;
        armed_q <= 1'b0;
        cnt_q   <= '0;
        if (armed_q && bit_cnt_i == '0 && !busy_i) begin
          if (op_q == OP_DP) pd_q <= 1'b1;
          else begin
            commit_q <= 1'b1;
            kind_q   <= kind_of(op_q);
          end
        end
      end else if (cs_active_i) begin
        if (byte_vld_i) begin
          case (phase_q)
            PH_OP: begin
              op_q     <= byte_i;
              cnt_q    <= '0;
              id_idx_q <= '0;
              if (pd_q) begin
                if (byte_i == OP_RES) begin
                  pd_q    <= 1'b0;
                  phase_q <= PH_ADDR;
                end else phase_q <= PH_SKIP;
              end else if (busy_i && byte_i != OP_RDSR) begin
                phase_q <= PH_SKIP;
              end else begin
                case (byte_i)
                  OP_WREN, OP_WRDI, OP_BE, OP_DP: begin
                    phase_q <= PH_HOLD;
                    armed_q <= 1'b1;
                  end
                  OP_RDSR, OP_RDID:                 phase_q <= PH_DOUT;
                  OP_WRSR:                          phase_q <= PH_DIN;
                  OP_READ, OP_FAST, OP_PP, OP_SE,
                  OP_RES:                           phase_q <= PH_ADDR;
                  default:                          phase_q <= PH_SKIP;
                endcase
              end
            end
            PH_ADDR: begin
              addr_q <= addr_nxt;
              cnt_q  <= cnt_q + 1'b1;
              if (cnt_q == 2'(ADDR_BYTES-1)) begin
                case (op_q)
                  OP_READ: begin
                    phase_q    <= PH_DOUT;
                    mem_rd_q   <= 1'b1;
                    mem_addr_q <= addr_nxt;
                  end
                  OP_FAST: phase_q <= PH_DUMMY;
                  OP_PP:   phase_q <= PH_DIN;
                  OP_SE: begin
                    phase_q <= PH_HOLD;
                    armed_q <= 1'b1;
                  end
                  default: phase_q <= PH_DOUT;
                endcase
              end
            end
            PH_DUMMY: begin
              phase_q    <= PH_DOUT;
              mem_rd_q   <= 1'b1;
              mem_addr_q <= addr_q;
            end
            PH_DIN: begin
              wvld_q  <= 1'b1;
              wdata_q <= byte_i;
              armed_q <= 1'b1;
            end
            default: ;
          endcase
        end
        if (load_i && phase_q == PH_DOUT) begin
          id_idx_q <= (id_idx_q == 2'd2) ? 2'd0 : id_idx_q + 1'b1;
          if (is_read) begin
            addr_q     <= addr_q + 1'b1;
            mem_addr_q <= addr_q + 1'b1;
            mem_rd_q   <= 1'b1;
          end
        end
      end
    end
  end

  assign mem_rd_o      = mem_rd_q;
  assign mem_addr_o    = mem_addr_q;
  assign dout_o        = (phase_q == PH_DOUT);
  assign commit_o      = commit_q;
  assign kind_o        = kind_q;
  assign cmd_addr_o    = addr_q;
  assign wr_data_o     = wdata_q;
  assign wr_data_vld_o = wvld_q;
  assign pd_o          = pd_q;

  assert_pd_no_dout_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_q |-> phase_q != PH_DOUT);
  assert_addr_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && phase_q == PH_DOUT && is_read && addr_q == '1) |=> addr_q == '0);
  assert_fetch_read_only_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_q |-> is_read);
  assert_commit_on_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_q |-> $past(cs_rise_i));
endmodule

// File: rtl/spi_flash_frontend.sv
module spi_flash_frontend #(
  parameter int ADDR_W    = 22,
  parameter int BYTE_W    = 8,
  parameter int SYNC_STG  = 2,
  localparam int BIT_W    = $clog2(BYTE_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              csn_i,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic              miso_oe_o,
  input  logic              busy_i,
  input  logic [BYTE_W-1:0] status_i,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [BYTE_W-1:0] mem_rdata_i,
  output logic              cmd_commit_o,
  output logic [2:0]        cmd_kind_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              wr_data_vld_o,
  output logic              powered_down_o
);
  logic sck_q, csn_q, mosi_q, sck_prev, csn_prev;
  logic sck_rise, sck_fall, cs_rise, cs_active;
  logic [BYTE_W-1:0] rx_byte, tx_byte;
  logic              rx_vld, load, dout;
  logic [BIT_W-1:0]  bit_cnt;

  sfl_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b0)) i_sync_sck
    (.clk_i(clk_i), .rst_ni(rst_ni), .d_i(sck_i),  .q_o(sck_q));
  sfl_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b1)) i_sync_csn
    (.clk_i(clk_i), .rst_ni(rst_ni), .d_i(csn_i),  .q_o(csn_q));
  sfl_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b0)) i_sync_mosi
    (.clk_i(clk_i), .rst_ni(rst_ni), .d_i(mosi_i), .q_o(mosi_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_prev <= 1'b0;
      csn_prev <= 1'b1;
    end else begin
      sck_prev <= sck_q;
      csn_prev <= csn_q;
    end
  end

  assign sck_rise  = sck_q & ~sck_prev;
  assign sck_fall  = ~sck_q & sck_prev;
  assign cs_rise   = csn_q & ~csn_prev;
  assign cs_active = ~csn_q;

  sfl_rx #(.BYTE_W(BYTE_W)) i_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_active_i(cs_active),
    .sck_rise_i(sck_rise), .sdi_i(mosi_q),
    .byte_o(rx_byte), .byte_vld_o(rx_vld), .bit_cnt_o(bit_cnt));

  sfl_ctrl #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) i_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_active_i(cs_active),
    .cs_rise_i(cs_rise), .byte_i(rx_byte), .byte_vld_i(rx_vld),
    .bit_cnt_i(bit_cnt), .load_i(load), .busy_i(busy_i),
    .status_i(status_i), .mem_rdata_i(mem_rdata_i),
    .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o), .tx_byte_o(tx_byte),
    .dout_o(dout), .commit_o(cmd_commit_o), .kind_o(cmd_kind_o),
    .cmd_addr_o(cmd_addr_o), .wr_data_o(wr_data_o),
    .wr_data_vld_o(wr_data_vld_o), .pd_o(powered_down_o));

  sfl_tx #(.BYTE_W(BYTE_W)) i_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_active_i(cs_active),
    .dout_i(dout), .sck_fall_i(sck_fall), .byte_i(tx_byte),
    .load_o(load), .sdo_o(miso_o), .oe_o(miso_oe_o));

  assert_commit_sel_high_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_commit_o |-> csn_q);
  assert_oe_sel_low_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csn_q && $past(csn_q)) |-> !miso_oe_o);
endmodule

// File: tb/test_spi_flash_frontend.sv
module test_spi_flash_frontend;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic sck = 1'b0, csn = 1'b1, mosi = 1'b0, busy = 1'b0;
  logic [7:0] status = 8'h00, mem_rdata = 8'h00;
  logic miso, miso_oe, mem_rd, commit, wvld, pd;
  logic [21:0] mem_addr, cmd_addr;
  logic [2:0] kind;
  logic [7:0] wdata;

  spi_flash_frontend i_spi_flash_frontend (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .csn_i(csn), .mosi_i(mosi),
    .miso_o(miso), .miso_oe_o(miso_oe), .busy_i(busy), .status_i(status),
    .mem_rd_o(mem_rd), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
    .cmd_commit_o(commit), .cmd_kind_o(kind), .cmd_addr_o(cmd_addr),
    .wr_data_o(wdata), .wr_data_vld_o(wvld), .powered_down_o(pd));

  int checks = 0, errors = 0, rd_cnt = 0, n_commit = 0, n_wd = 0;
  logic [2:0]  last_kind = '0;
  logic [21:0] last_addr = '0;
  logic [7:0]  wbuf [0:15];
  logic        oe_seen = 1'b0;

  function automatic logic [7:0] pat(input logic [21:0] a);
    return a[7:0] ^ a[15:8] ^ {2'b00, a[21:16]} ^ 8'h5A;
  endfunction

  always @(posedge clk) begin
    if (mem_rd) begin
      mem_rdata <= pat(mem_addr);
      rd_cnt++;
    end
    if (commit) begin
      n_commit++;
      last_kind = kind;
      last_addr = cmd_addr;
    end
    if (wvld) begin
      if (n_wd < 16) wbuf[n_wd] = wdata;
      n_wd++;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cs_lo();
    @(negedge clk);
    csn = 1'b0;
    oe_seen = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cs_hi();
    repeat (HALF) @(negedge clk);
    csn = 1'b1;
    repeat (12) @(negedge clk);
    check("R1 oe after deselect", {31'd0, miso_oe}, 32'd0);
  endtask

  task automatic xbits(input int n, input logic [7:0] tx, output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 0; i < n; i++) begin
      mosi = tx[7-i];
      repeat (HALF) @(negedge clk);
      rx[7-i] = miso;
      if (miso_oe) oe_seen = 1'b1;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic xb(input logic [7:0] tx, output logic [7:0] rx);
    xbits(8, tx, rx);
  endtask

  task automatic send(input logic [7:0] tx);
    logic [7:0] d;
    xb(tx, d);
  endtask

  task automatic do_read(input string req, input logic [7:0] op, input logic [23:0] a,
                         input int dummy, input int n);
    logic [7:0] d;
    logic [21:0] ea;
    cs_lo();
    send(op);
    send(a[23:16]); send(a[15:8]); send(a[7:0]);
    for (int k = 0; k < dummy; k++) send(8'h00);
    for (int k = 0; k < n; k++) begin
      xb(8'h00, d);
      ea = a[21:0] + 22'(k);
      check(req, {24'd0, d}, {24'd0, pat(ea)});
    end
    check({req, " oe"}, {31'd0, oe_seen}, 32'd1);
    cs_hi();
  endtask

  task automatic expect_commit(input string req, input int base, input logic [2:0] k,
                               input logic [21:0] a);
    check(req, n_commit - base, 1);
    check({req, " kind"}, {29'd0, last_kind}, {29'd0, k});
    check({req, " addr"}, {10'd0, last_addr}, {10'd0, a});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int base, rb;
    logic [23:0] addrs [0:5];

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 oe reset", {31'd0, miso_oe}, 32'd0);
    check("R1 pd reset", {31'd0, pd}, 32'd0);
    check("R1 mem_rd reset", {31'd0, mem_rd}, 32'd0);
    check("R1 commit reset", n_commit, 0);

    // R2 R3 read sweep, upper address bits ignored, wrap at top
    addrs[0] = 24'h000000; addrs[1] = 24'h123456; addrs[2] = 24'hC0FF00;
    addrs[3] = 24'h3FFFFE; addrs[4] = 24'hFFFFFF; addrs[5] = 24'h2AAAA9;
    for (int i = 0; i < 6; i++) do_read("R2 R3 read", 8'h03, addrs[i], 0, 4);

    // R4 fast read with one dummy byte, across the wrap
    do_read("R4 fast read", 8'h0B, 24'h7FFFFF, 1, 3);
    do_read("R4 fast read", 8'h0B, 24'h001234, 1, 2);

    // R5 identification cycle
    cs_lo();
    send(8'h9F);
    for (int k = 0; k < 6; k++) begin
      xb(8'h00, d);
      check("R5 rdid", {24'd0, d}, (k % 3 == 2) ? 32'h16 : 32'h20);
    end
    cs_hi();

    // R6 status read
    for (int v = 0; v < 4; v++) begin
      status = 8'(v * 8'h4B + 8'h11);
      cs_lo();
      send(8'h05);
      xb(8'h00, d);
      check("R6 rdsr", {24'd0, d}, {24'd0, status});
      xb(8'h00, d);
      check("R6 rdsr repeat", {24'd0, d}, {24'd0, status});
      cs_hi();
    end

    // R7 opcode-only commits
    base = n_commit; cs_lo(); send(8'h06); cs_hi();
    expect_commit("R7 wren", base, 3'd0, last_addr);
    base = n_commit; cs_lo(); send(8'h04); cs_hi();
    expect_commit("R7 wrdi", base, 3'd1, last_addr);
    base = n_commit; cs_lo(); send(8'hC7); cs_hi();
    expect_commit("R7 be", base, 3'd5, last_addr);
    // R7 off-boundary and extra-byte cases
    base = n_commit; cs_lo(); send(8'h06); xbits(1, 8'h80, d); cs_hi();
    check("R7 wren extra bit", n_commit - base, 0);
    base = n_commit; cs_lo(); send(8'h06); send(8'h00); cs_hi();
    check("R7 wren extra byte", n_commit - base, 1);
    base = n_commit; cs_lo(); send(8'hD8); send(8'h12); send(8'h34); cs_hi();
    check("R7 se short", n_commit - base, 0);
    base = n_commit; cs_lo(); send(8'hD8); send(8'hD2); send(8'h34); send(8'h56); cs_hi();
    expect_commit("R7 se", base, 3'd4, 22'h123456);
    base = n_commit; cs_lo(); send(8'h02); send(8'h01); send(8'h02); send(8'h03); cs_hi();
    check("R7 pp no data", n_commit - base, 0);

    // R8 page program and status write data
    base = n_commit; n_wd = 0;
    cs_lo(); send(8'h02); send(8'h3F); send(8'hFF); send(8'h00);
    for (int k = 0; k < 3; k++) send(8'(8'hA0 + k));
    cs_hi();
    expect_commit("R8 pp", base, 3'd3, 22'h3FFF00);
    check("R8 pp count", n_wd, 3);
    for (int k = 0; k < 3; k++) check("R8 pp data", {24'd0, wbuf[k]}, 32'hA0 + k);
    base = n_commit; n_wd = 0;
    cs_lo(); send(8'h01); send(8'h9C); cs_hi();
    check("R8 wrsr count", n_wd, 1);
    check("R8 wrsr data", {24'd0, wbuf[0]}, 32'h9C);
    check("R7 wrsr commit", n_commit - base, 1);
    check("R7 wrsr kind", {29'd0, last_kind}, 32'd2);

    // R13 unknown opcode
    base = n_commit; rb = rd_cnt;
    cs_lo(); send(8'h77); send(8'h03); send(8'h00); send(8'h06); cs_hi();
    check("R13 unknown oe", {31'd0, oe_seen}, 32'd0);
    check("R13 unknown commit", n_commit - base, 0);
    check("R13 unknown fetch", rd_cnt - rb, 0);

    // R9 R10 busy handling
    busy = 1'b1; status = 8'h81;
    base = n_commit; rb = rd_cnt;
    cs_lo(); send(8'h03); send(8'h00); send(8'h00); send(8'h10); xb(8'h00, d); cs_hi();
    check("R9 busy read oe", {31'd0, oe_seen}, 32'd0);
    check("R9 busy read fetch", rd_cnt - rb, 0);
    cs_lo(); send(8'h06); cs_hi();
    check("R9 busy wren", n_commit - base, 0);
    cs_lo(); send(8'h05); xb(8'h00, d); cs_hi();
    check("R9 busy rdsr", {24'd0, d}, 32'h81);
    cs_lo(); send(8'hB9); cs_hi();
    check("R10 busy dp rejected", {31'd0, pd}, 32'd0);
    busy = 1'b0;

    // R10 R11 power-down
    cs_lo(); send(8'hB9); cs_hi();
    check("R10 dp", {31'd0, pd}, 32'd1);
    cs_lo(); send(8'h9F); xb(8'h00, d); cs_hi();
    check("R11 pd rdid oe", {31'd0, oe_seen}, 32'd0);
    base = n_commit;
    cs_lo(); send(8'h06); cs_hi();
    check("R11 pd wren", n_commit - base, 0);
    check("R11 pd held", {31'd0, pd}, 32'd1);

    // R12 release with early deselect, then full signature
    cs_lo(); send(8'hAB); cs_hi();
    check("R12 early wake", {31'd0, pd}, 32'd0);
    cs_lo(); send(8'hB9); cs_hi();
    check("R10 dp again", {31'd0, pd}, 32'd1);
    cs_lo(); send(8'hAB);
    for (int k = 0; k < 3; k++) send(8'h00);
    for (int k = 0; k < 2; k++) begin
      xb(8'h00, d);
      check("R12 signature", {24'd0, d}, 32'h15);
    end
    cs_hi();
    check("R12 awake", {31'd0, pd}, 32'd0);
    do_read("R12 read after wake", 8'h03, 24'h0ABCDE, 0, 2);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule